// File: doc/BRIEF.md
# Block Common Exponent Normalizer

This block rescales a block of complex fixed-point samples that sit in an external RAM. Each word holds one complex sample: two 16-bit two's-complement fractions, with the real part in bits [15:0] and the imaginary part in bits [31:16]. After a start pulse the block reads every word and finds the single component, real or imaginary, with the largest magnitude. It then picks one shift amount that moves that component into a headroom window. The window leaves either one or two spare magnitude bits, so that the next arithmetic stage can grow without overflow. The block writes every word back shifted by that same amount and reports the shift.

A signed running exponent adds up the shifts of successive calls, so a caller that normalises a buffer before each processing stage ends with the power of two that recovers the true output scale (true value = mantissa × 2^exponent). A dedicated clear input starts a new accumulation. The work takes two passes: a scan pass that reads each word, then a rewrite pass of read, capture and write for each word. The rewrite pass is left out when the shift is zero.

Top module: `bfpn_normalizer`

## Requirements
- R1: After reset, busy, done, mem_rd_en and mem_wr_en are low, and shift_out and blk_exp are zero.
- R2: The size of a component is measured by its redundant sign bits: the number of bits below bit 15 that equal bit 15 (0 to 15). The shift is set only by the smallest such count over the real and imaginary parts of all words. For example, -16384 has 1, -16385 has 0 and 0 has 15.
- R3: With headroom_sel = 0, shift_out = 1 - (smallest count). After the rewrite, the smallest count in the block is exactly 1, so a positive peak lies in 8192..16383.
- R4: With headroom_sel = 1, shift_out = 2 - (smallest count). After the rewrite, the smallest count is exactly 2, so a positive peak lies in 4096..8191.
- R5: A positive shift_out is an arithmetic right shift that rounds toward minus infinity, and a negative one is a left shift. A block holding -32768 always gives a right shift.
- R6: Every real and imaginary part of every word is rewritten with the same shift, and the word layout is kept.
- R7: When the shift is zero, no write is issued and the RAM is left unchanged. Writes happen only while busy.
- R8: done is a one-cycle pulse with busy low. When a rewrite took place, done rises in the cycle after the cycle that held the last write, and each address is written exactly once.
- R9: blk_exp is a signed 6-bit register that adds each call's shift_out, wrapping in two's complement. It changes only during a call or after a clear.
- R10: exp_clr sets blk_exp to zero on the next edge, and it takes priority over an update in the same cycle.
- R11: A start pulse that arrives while busy is ignored, including its headroom_sel value.
- R12: The block expects read data one cycle after mem_rd_en, and it never asserts mem_rd_en and mem_wr_en in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a call when idle |
| headroom_sel | input | 1 | 0: one spare bit, 1: two spare bits (sampled at start) |
| exp_clr | input | 1 | Clear the running exponent |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| busy | output | 1 | A call is in progress |
| done | output | 1 | One-cycle pulse at the end of a call |
| shift_out | output | 5 | Signed shift of the last call (positive = right) |
| blk_exp | output | 6 | Signed running exponent |
| mem_addr | output | 4 | RAM word address |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wdata | output | 32 | RAM write data |

## Verification
Pseudo-random blocks are seeded with a planted peak, and each block isolates one path. A small positive peak in the imaginary lane drives a large left shift. A large negative real peak drives a right shift in two-bit mode. A block holding -32768 tests the full-scale negative case. Two peaks that are already inside the window, 10000 and -16384, show that the rewrite is skipped and that the negative edge of the window is handled. An all-zero block gives the largest left shift. A second start sent mid-call with the other mode tells whether the running call keeps its settings. The running exponent is followed across these calls and through a clear, which separates accumulation from overwrite.

// File: rtl/bfpn_pkg.sv
`timescale 1ns/1ps
package bfpn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_TAIL,
    ST_EVAL,
    ST_RD,
    ST_CAP,
    ST_WR
  } bfpn_state_e;

  localparam int HEADROOM_ONE = 1;
  localparam int HEADROOM_TWO = 2;
endpackage

// File: rtl/bfpn_sign_count.sv
`timescale 1ns/1ps
// Counts the bits directly below the sign bit that repeat the sign.
module bfpn_sign_count #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  value,
  output logic [CW-1:0] count
);
  logic run;

  always_comb begin
    count = '0;
    run   = 1'b1;
    for (int i = W-2; i >= 0; i--) begin
      if (run && (value[i] == value[W-1])) begin
        count = count + CW'(1);
      end else begin
        run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bfpn_peak_track.sv
`timescale 1ns/1ps
// Keeps the smallest redundant-sign count seen across all lanes of a pass.
module bfpn_peak_track #(
  parameter int W     = 16,
  parameter int LANES = 2,
  parameter int CW    = $clog2(W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               sample_v,
  input  logic [LANES*W-1:0] lanes,
  output logic [CW-1:0]      min_q
);
  localparam logic [CW-1:0] CNT_MAX = CW'(W-1);

  logic [CW-1:0] cnt [LANES];
  logic [CW-1:0] cand;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bfpn_sign_count #(.W(W), .CW(CW)) u_cnt (
      .value (lanes[l*W +: W]),
      .count (cnt[l])
    );
  end

  always_comb begin
    cand = CNT_MAX;
    for (int l = 0; l < LANES; l++) begin
      if (cnt[l] < cand) cand = cnt[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      min_q <= CNT_MAX;
    end else if (sample_v && (cand < min_q)) begin
      min_q <= cand;
    end
  end
endmodule

// File: rtl/bfpn_shift_plan.sv
`timescale 1ns/1ps
// Turns the block's smallest sign count into a signed shift (positive = right).
module bfpn_shift_plan
  import bfpn_pkg::*;
#(
  parameter int CW   = 4,
  parameter int SH_W = CW + 1
) (
  input  logic                   two_bit,
  input  logic [CW-1:0]          min_ls,
  output logic signed [SH_W-1:0] plan
);
  logic signed [SH_W-1:0] target;
  logic signed [SH_W-1:0] have;

  always_comb begin
    target = two_bit ? SH_W'(HEADROOM_TWO) : SH_W'(HEADROOM_ONE);
    have   = SH_W'(min_ls);
    plan   = target - have;
  end
endmodule

// File: rtl/bfpn_scaler.sv
`timescale 1ns/1ps
// Applies one signed shift to every lane: arithmetic right or plain left.
module bfpn_scaler #(
  parameter int W     = 16,
  parameter int LANES = 2,
  parameter int SH_W  = 5
) (
  input  logic [LANES*W-1:0]     lanes_in,
  input  logic signed [SH_W-1:0] amount,
  output logic [LANES*W-1:0]     lanes_out
);
  logic [SH_W-1:0] mag;

  always_comb begin
    mag = amount[SH_W-1] ? SH_W'(-amount) : SH_W'(amount);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [W-1:0] din;
    always_comb begin
      din = $signed(lanes_in[l*W +: W]);
      if (amount[SH_W-1]) begin
        lanes_out[l*W +: W] = din << mag;
      end else begin
        lanes_out[l*W +: W] = din >>> mag;
      end
    end
  end
endmodule

// File: rtl/bfpn_normalizer.sv
`timescale 1ns/1ps
module bfpn_normalizer
  import bfpn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int EXP_W  = 6,
  parameter int SH_W   = $clog2(DATA_W) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   headroom_sel,
  input  logic                   exp_clr,
  input  logic [2*DATA_W-1:0]    mem_rdata,
  output logic                   busy,
  output logic                   done,
  output logic signed [SH_W-1:0] shift_out,
  output logic signed [EXP_W-1:0] blk_exp,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_rd_en,
  output logic                   mem_wr_en,
  output logic [2*DATA_W-1:0]    mem_wdata
);
  localparam int LANES = 2;
  localparam int CW    = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  bfpn_state_e state;
  logic                   mode_q;
  logic                   scan_v;
  logic [CW-1:0]          min_ls;
  logic signed [SH_W-1:0] plan;
  logic [2*DATA_W-1:0]    scaled;
  logic                   take_start;

  assign take_start = (state == ST_IDLE) && start;

  bfpn_peak_track #(.W(DATA_W), .LANES(LANES), .CW(CW)) u_peak (
    .clk      (clk),
    .rst      (rst),
    .clear    (take_start),
    .sample_v (scan_v),
    .lanes    (mem_rdata),
    .min_q    (min_ls)
  );

  bfpn_shift_plan #(.CW(CW), .SH_W(SH_W)) u_plan (
    .two_bit (mode_q),
    .min_ls  (min_ls),
    .plan    (plan)
  );

  bfpn_scaler #(.W(DATA_W), .LANES(LANES), .SH_W(SH_W)) u_scale (
    .lanes_in  (mem_rdata),
    .amount    (shift_out),
    .lanes_out (scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= 1'b0;
      scan_v    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      shift_out <= '0;
      blk_exp   <= '0;
      mem_addr  <= '0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_wdata <= '0;
    end else begin
      done   <= 1'b0;
      scan_v <= (state == ST_SCAN);

      if (exp_clr) begin
        blk_exp <= '0;
      end else if (state == ST_EVAL) begin
        blk_exp <= blk_exp + EXP_W'(plan);
      end

      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q    <= headroom_sel;
            mem_addr  <= '0;
            mem_rd_en <= 1'b1;
            busy      <= 1'b1;
            state     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (mem_addr == LAST_ADDR) begin
            mem_rd_en <= 1'b0;
            state     <= ST_TAIL;
          end else begin
            mem_addr <= mem_addr + ADDR_W'(1);
          end
        end
        ST_TAIL: state <= ST_EVAL;
        ST_EVAL: begin
          shift_out <= plan;
          if (plan == '0) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            mem_addr  <= '0;
            mem_rd_en <= 1'b1;
            state     <= ST_RD;
          end
        end
        ST_RD: begin
          mem_rd_en <= 1'b0;
          state     <= ST_CAP;
        end
        ST_CAP: begin
          mem_wr_en <= 1'b1;
          mem_wdata <= scaled;
          state     <= ST_WR;
        end
        ST_WR: begin
          mem_wr_en <= 1'b0;
          if (mem_addr == LAST_ADDR) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            mem_addr  <= mem_addr + ADDR_W'(1);
            mem_rd_en <= 1'b1;
            state     <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bfpn_normalizer_chk.sv
`timescale 1ns/1ps
module bfpn_normalizer_chk #(
  parameter int DATA_W = 16,
  parameter int EXP_W  = 6,
  parameter int SH_W   = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic                   exp_clr,
  input logic                   busy,
  input logic                   done,
  input logic signed [SH_W-1:0] shift_out,
  input logic [EXP_W-1:0]       blk_exp,
  input logic                   mem_rd_en,
  input logic                   mem_wr_en
);
  localparam int MIN_SHIFT = -(DATA_W - 2);

  a_r12_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r5_shift_bounds: assert property (@(posedge clk) disable iff (rst)
    done |-> (($signed(shift_out) <= 2) && ($signed(shift_out) >= MIN_SHIFT)));

  a_r9_exp_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(blk_exp) |-> ($past(exp_clr) || $past(busy)));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    exp_clr |=> (blk_exp == '0));

  a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  a_r7_write_busy: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> busy);
endmodule

bind bfpn_normalizer bfpn_normalizer_chk #(
  .DATA_W (DATA_W),
  .EXP_W  (EXP_W),
  .SH_W   (SH_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .exp_clr   (exp_clr),
  .busy      (busy),
  .done      (done),
  .shift_out (shift_out),
  .blk_exp   (blk_exp),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en)
);

// File: tb/bfpn_normalizer_bench.sv
`timescale 1ns/1ps
module bfpn_normalizer_bench;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int EW = 6;
  localparam int SW = 5;
  localparam int NW = 1 << AW;

  typedef struct {
    int shift;
    int expo;
    int writes;
  } exp_item_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, headroom_sel = 1'b0, exp_clr = 1'b0;
  logic [2*DW-1:0] mem_rdata;
  logic busy, done, mem_rd_en, mem_wr_en;
  logic signed [SW-1:0] shift_out;
  logic signed [EW-1:0] blk_exp;
  logic [AW-1:0] mem_addr;
  logic [2*DW-1:0] mem_wdata;

  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [2*DW-1:0] ld_data = '0;
  logic [2*DW-1:0] ram [NW];

  int checks = 0, errors = 0;
  int cyc = 0, wr_cnt = 0, last_wr_cyc = 0, done_cnt = 0, port_bad = 0;
  int exp_model = 0;
  int seed = 7;
  logic [DW-1:0] st_re [NW];
  logic [DW-1:0] st_im [NW];
  exp_item_t sb_q[$];

  bfpn_normalizer #(.DATA_W(DW), .ADDR_W(AW), .EXP_W(EW)) u_bfpn_normalizer (
    .clk(clk), .rst(rst), .start(start), .headroom_sel(headroom_sel),
    .exp_clr(exp_clr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .shift_out(shift_out), .blk_exp(blk_exp), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (ld_en) ram[ld_addr] <= ld_data;
    else if (mem_wr_en) ram[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int ref_ls(input logic [DW-1:0] v);
    logic [DW-2:0] x;
    bit found;
    int r;
    x = v[DW-2:0] ^ {(DW-1){v[DW-1]}};
    r = DW - 1;
    found = 1'b0;
    for (int i = DW-2; i >= 0; i--) begin
      if (!found && x[i]) begin
        r = DW - 2 - i;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] ref_scale(input logic [DW-1:0] v, input int s);
    logic signed [DW-1:0] sv;
    sv = $signed(v);
    if (s > 0) return DW'(sv >>> s);
    return DW'(v << (-s));
  endfunction

  // Scoreboard monitor: compares each done against the oldest queued item.
  always @(negedge clk) begin
    exp_item_t it;
    cyc++;
    if (!rst) begin
      if (mem_rd_en && mem_wr_en) port_bad++;
      if (mem_wr_en) begin
        wr_cnt++;
        last_wr_cyc = cyc;
      end
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected done", done_cnt, 0);
        end else begin
          it = sb_q.pop_front();
          chk(int'(shift_out) == it.shift, "R3/R4/R5", "shift_out", int'(shift_out), it.shift);
          chk(int'(blk_exp) == it.expo, "R9", "blk_exp", int'(blk_exp), it.expo);
          chk(wr_cnt == it.writes, "R7/R8", "write count", wr_cnt, it.writes);
          if (it.writes > 0)
            chk(cyc == last_wr_cyc + 1, "R8", "done cycle after last write", cyc, last_wr_cyc + 1);
          chk(!busy, "R8", "busy with done", int'(busy), 0);
        end
        wr_cnt = 0;
        done_cnt++;
      end
    end
  end

  task automatic fill(input int lim);
    for (int i = 0; i < NW; i++) begin
      seed = seed * 1103515245 + 12345;
      st_re[i] = DW'(((seed >>> 16) & 32'h7fff) % (2*lim) - lim);
      seed = seed * 1103515245 + 12345;
      st_im[i] = DW'(((seed >>> 16) & 32'h7fff) % (2*lim) - lim);
    end
  endtask

  task automatic run_block(input bit m, input bit dup_start, input string tag);
    exp_item_t it;
    int mn, sh, t, bad, after_min, d0;
    bit all_zero;
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = {st_im[i], st_re[i]};
    end
    @(negedge clk);
    ld_en = 1'b0;
    mn = DW - 1;
    all_zero = 1'b1;
    for (int i = 0; i < NW; i++) begin
      if (ref_ls(st_re[i]) < mn) mn = ref_ls(st_re[i]);
      if (ref_ls(st_im[i]) < mn) mn = ref_ls(st_im[i]);
      if (st_re[i] != 0 || st_im[i] != 0) all_zero = 1'b0;
    end
    sh = (m ? 2 : 1) - mn;
    exp_model = int'($signed(EW'(exp_model + sh)));
    it.shift = sh; it.expo = exp_model; it.writes = (sh == 0) ? 0 : NW;
    sb_q.push_back(it);
    d0 = done_cnt;
    headroom_sel = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dup_start) begin
      repeat (4) @(negedge clk);
      headroom_sel = ~m; start = 1'b1;
      @(negedge clk);
      start = 1'b0; headroom_sel = m;
    end
    t = 0;
    while (done_cnt == d0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, "R8", {tag, " watchdog on done"}, t, 0);
    bad = 0;
    after_min = DW - 1;
    for (int i = 0; i < NW; i++) begin
      if (ram[i] != {ref_scale(st_im[i], sh), ref_scale(st_re[i], sh)}) bad++;
      if (ref_ls(ram[i][DW-1:0]) < after_min) after_min = ref_ls(ram[i][DW-1:0]);
      if (ref_ls(ram[i][2*DW-1:DW]) < after_min) after_min = ref_ls(ram[i][2*DW-1:DW]);
    end
    chk(bad == 0, (sh == 0) ? "R7" : "R6", {tag, " ram words wrong"}, bad, 0);
    if (!all_zero)
      chk(after_min == (m ? 2 : 1), m ? "R4" : "R3", {tag, " window after rewrite"}, after_min, m ? 2 : 1);
    if (dup_start) begin
      repeat (40) @(negedge clk);
      chk(done_cnt == d0 + 1, "R11", {tag, " extra done after second start"}, done_cnt, d0 + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R8", "global watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", int'(busy) + int'(done), 0);
    chk(!mem_rd_en && !mem_wr_en, "R1", "ram strobes after reset", int'(mem_rd_en) + int'(mem_wr_en), 0);
    chk(shift_out == 0, "R1", "shift_out after reset", int'(shift_out), 0);
    chk(blk_exp == 0, "R1", "blk_exp after reset", int'(blk_exp), 0);

    // R2: small positive peak in the imaginary lane, left shift by 5
    fill(200); st_im[5] = 16'd300;
    run_block(1'b0, 1'b0, "R2 small peak");
    // R4/R5: large negative real peak, two-bit mode, right shift by 2
    fill(3000); st_re[9] = 16'(-20000);
    run_block(1'b1, 1'b0, "R4 neg peak");
    // R5: full-scale negative forces right shift
    fill(1000); st_re[0] = 16'h8000;
    run_block(1'b0, 1'b0, "R5 full scale");
    // R7: already inside the window, no rewrite
    fill(5000); st_im[15] = 16'd10000;
    run_block(1'b0, 1'b0, "R7 in window");
    // R2 boundary: -16384 has one redundant sign bit, no shift
    fill(4000); st_re[3] = 16'(-16384);
    run_block(1'b0, 1'b0, "R2 neg edge");

    // R10: clear the running exponent
    @(negedge clk);
    exp_clr = 1'b1;
    @(negedge clk);
    exp_clr = 1'b0;
    chk(blk_exp == 0, "R10", "blk_exp after clear", int'(blk_exp), 0);
    exp_model = 0;

    // R6/R9: all-zero block, largest left shift
    for (int i = 0; i < NW; i++) begin st_re[i] = '0; st_im[i] = '0; end
    run_block(1'b1, 1'b0, "R6 zeros");
    // R11: second start mid-call with the other mode is ignored
    fill(100); st_re[7] = 16'd4095;
    run_block(1'b1, 1'b1, "R11 dup start");

    chk(port_bad == 0, "R12", "read and write in one cycle", port_bad, 0);
    chk(sb_q.size() == 0, "R8", "items left in scoreboard", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule